// File: doc/BRIEF.md
# Forwarding Simple Dual-Port Memory

This block is a single-clock memory with one write port and one read port, each with its own address. The storage array on its own returns old data when both ports hit the same location in one cycle. A small registered bypass in front of the read data hides that: when a write and a read target the same address in the same cycle, the read returns the word being written. Logic that reads a location in the same cycle it updates it can therefore use the block without extra hazard handling.

Read data can come straight from the first read stage, one cycle after the address. A parameter can instead add an output register, which gives two cycles of latency. The read enable only gates that added register and is used to save power. The first stage loads from the array on every clock. Memory contents are undefined until written.

Top module: `fwd_sdp_ram`

## Requirements
- R1: While `rst` is high at a clock edge, `rd_data` reads zero after that edge in both output modes. Stored contents are not cleared.
- R2: With `OUT_MODE` = OUT_DIRECT (0), `rd_data` after clock edge N holds the stored word at the `rd_addr` sampled at edge N.
- R3: A write to one address does not change the data returned for a read of a different address in the same cycle.
- R4: When `wr_en` is high and `wr_addr` equals `rd_addr` at an edge, the read returns the `wr_data` of that edge, not the previous contents.
- R5: When the addresses are equal but `wr_en` is low, the read returns the stored word.
- R6: With `OUT_MODE` = OUT_STAGED (1), at each edge where `rd_en` is high, the output register loads the first-stage value formed from the previous edge's inputs. The latency is two cycles.
- R7: With OUT_STAGED and `rd_en` low at an edge, `rd_data` keeps its value. This includes a value that was forwarded.
- R8: With OUT_DIRECT, `rd_en` has no effect on `rd_data`.
- R9: Back-to-back writes to one address, each read in the same cycle, return each new word in turn. A later read returns the last word written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for both ports |
| rst | input | 1 | Synchronous active-high reset of read-path registers |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write location |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Load enable of the optional output register |
| rd_addr | input | ADDR_W | Read location |
| rd_data | output | DATA_W | Read word, with same-cycle write forwarded |

## Verification
The direct-mode result for inputs presented at edge N is due just after edge N. The staged-mode result is due after edge N+1, and only if `rd_en` is high at that edge. The bench drives each operation at a falling edge and samples two nanoseconds after the following rising edge. It keeps one expected value per mode: the direct value is replaced every cycle, and the staged value takes over the previous direct value only when the `rd_enable` stimulus of that cycle is high. Words read from locations not yet written are marked unknown and skipped. A forwarded collision is always known.

// File: rtl/fwd_ram_pkg.sv
package fwd_ram_pkg;
    // Read-path variant: first stage only, or an added gated register
    typedef enum logic {
        OUT_DIRECT = 1'b0,
        OUT_STAGED = 1'b1
    } out_mode_e;
endpackage

// File: rtl/fr_array.sv
// Storage array with a registered read; old data on same-address collision
module fr_array #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [DATA_W-1:0] word;
    } arr_st_t;

    logic [DATA_W-1:0] mem [DEPTH];
    arr_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.word = mem[rd_addr];
        if (rst) s_d.word = '0;
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    // Array write; non-blocking so a same-edge read sees the old word
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_word = s_q.word;
endmodule

// File: rtl/fr_bypass.sv
// Registers the collision condition and the written word for forwarding
module fr_bypass #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              hit,
    output logic [DATA_W-1:0] fwd_word
);
    typedef struct packed {
        logic              hit;
        logic [DATA_W-1:0] word;
    } byp_st_t;

    byp_st_t s_d, s_q;
    logic    same_cycle_hit;

    always_comb begin
        same_cycle_hit = wr_en && (wr_addr == rd_addr);
        s_d            = s_q;
        s_d.hit        = same_cycle_hit;
        // Capture the word only when it will be forwarded
        if (same_cycle_hit) s_d.word = wr_data;
        if (rst) begin
            s_d.hit  = 1'b0;
            s_d.word = '0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign hit      = s_q.hit;
    assign fwd_word = s_q.word;
endmodule

// File: rtl/fr_outstage.sv
// Forwarding multiplexer plus optional enable-gated output register
module fr_outstage
    import fwd_ram_pkg::*;
#(
    parameter int        DATA_W   = 16,
    parameter out_mode_e OUT_MODE = OUT_STAGED
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              hit,
    input  logic [DATA_W-1:0] fwd_word,
    input  logic [DATA_W-1:0] arr_word,
    output logic [DATA_W-1:0] stage_word,
    output logic [DATA_W-1:0] rd_data
);
    assign stage_word = hit ? fwd_word : arr_word;

    generate
        if (OUT_MODE == OUT_STAGED) begin : g_staged
            typedef struct packed {
                logic [DATA_W-1:0] word;
            } out_st_t;

            out_st_t s_d, s_q;

            always_comb begin
                s_d = s_q;
                if (rd_en) s_d.word = stage_word;
                if (rst) s_d.word = '0;
            end

            always_ff @(posedge clk) begin
                s_q <= s_d;
            end

            assign rd_data = s_q.word;
        end else begin : g_direct
            logic unused_ctl;
            assign unused_ctl = ^{rd_en, clk, rst};
            assign rd_data    = stage_word;
        end
    endgenerate
endmodule

// File: rtl/fwd_sdp_ram.sv
// Simple dual-port memory with same-cycle write forwarding on the read port
module fwd_sdp_ram
    import fwd_ram_pkg::*;
#(
    parameter int        DATA_W   = 16,
    parameter int        ADDR_W   = 6,
    parameter out_mode_e OUT_MODE = OUT_STAGED
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] arr_word;
    logic [DATA_W-1:0] fwd_word;
    logic [DATA_W-1:0] stage_word;
    logic              hit;

    fr_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_word (arr_word)
    );

    fr_bypass #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bypass (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .hit      (hit),
        .fwd_word (fwd_word)
    );

    fr_outstage #(.DATA_W(DATA_W), .OUT_MODE(OUT_MODE)) u_out (
        .clk        (clk),
        .rst        (rst),
        .rd_en      (rd_en),
        .hit        (hit),
        .fwd_word   (fwd_word),
        .arr_word   (arr_word),
        .stage_word (stage_word),
        .rd_data    (rd_data)
    );
endmodule

// File: rtl/fwd_sdp_ram_chk.sv
module fwd_sdp_ram_chk
    import fwd_ram_pkg::*;
#(
    parameter int        DATA_W   = 16,
    parameter int        ADDR_W   = 6,
    parameter out_mode_e OUT_MODE = OUT_STAGED
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic [DATA_W-1:0] stage_word
);
    localparam bit STAGED = (OUT_MODE == OUT_STAGED);

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> (rd_data == '0));

    // R4
    collision_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr == rd_addr)) |=> (stage_word == $past(wr_data)));

    // R6
    staged_load_chk: assert property (@(posedge clk) disable iff (rst)
        (STAGED && rd_en && !$past(rst)) |=> (rd_data == $past(stage_word)));

    // R7
    staged_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (STAGED && !rd_en) |=> $stable(rd_data));

    // R8
    direct_path_chk: assert property (@(posedge clk) disable iff (rst)
        (!STAGED && !rd_en && wr_en && (wr_addr == rd_addr)) |=> (rd_data == $past(wr_data)));
endmodule

bind fwd_sdp_ram fwd_sdp_ram_chk #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .OUT_MODE (OUT_MODE)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .stage_word (stage_word)
);

// File: tb/sim_fwd_sdp_ram.sv
`timescale 1ns/1ps
module sim_fwd_sdp_ram;
    import fwd_ram_pkg::*;

    localparam int DW    = 16;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] q_dir;
    logic [DW-1:0] q_stg;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] model [DEPTH];
    bit            known [DEPTH];
    logic [DW-1:0] exp1 = '0;
    bit            exp1_ok = 1'b1;
    logic [DW-1:0] exp2 = '0;
    bit            exp2_ok = 1'b1;

    always #4 clk = ~clk;   // 125 MHz

    fwd_sdp_ram #(.DATA_W(DW), .ADDR_W(AW), .OUT_MODE(OUT_DIRECT)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(q_dir)
    );

    fwd_sdp_ram #(.DATA_W(DW), .ADDR_W(AW), .OUT_MODE(OUT_STAGED)) u1 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(q_stg)
    );

    task automatic check(input string tag, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One clock of traffic; direct result checked after this edge,
    // staged result reflects the previous cycle's first-stage value.
    task automatic step(input bit we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                        input logic [AW-1:0] ra, input bit re, input string tag);
        logic [DW-1:0] n1;
        bit            n1ok;
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra; rd_en = re;
        if (we && wa == ra) begin
            n1 = wd; n1ok = 1'b1;
        end else begin
            n1 = model[ra]; n1ok = known[ra];
        end
        @(posedge clk);
        if (we) begin
            model[wa] = wd; known[wa] = 1'b1;
        end
        if (re) begin
            exp2 = exp1; exp2_ok = exp1_ok;
        end
        exp1 = n1; exp1_ok = n1ok;
        #2;
        if (exp1_ok) check(tag, "direct", q_dir, exp1);
        if (exp2_ok) check(tag, "staged", q_stg, exp2);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        check("R1", "direct in reset", q_dir, '0);
        check("R1", "staged in reset", q_stg, '0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_fill_and_read;
        for (int i = 0; i < DEPTH; i++)
            step(1'b1, AW'(i), DW'(16'h1000 + i * 7), AW'((i + 1) % DEPTH), 1'b0, "R2");
        for (int i = 0; i < DEPTH; i++)
            step(1'b0, '0, '0, AW'(i), 1'b1, "R6");
        step(1'b0, '0, '0, '0, 1'b1, "R6");
    endtask

    task automatic t_other_addr;
        for (int i = 0; i < 8; i++)
            step(1'b1, AW'(i), DW'(16'hA500 + i), AW'(i + 20), 1'b1, "R3");
        step(1'b0, '0, '0, AW'(3), 1'b1, "R3");
        step(1'b0, '0, '0, AW'(3), 1'b1, "R3");
    endtask

    task automatic t_collide;
        for (int i = 0; i < 4; i++)
            step(1'b1, AW'(40 + i), DW'(16'hC0DE ^ i), AW'(40 + i), 1'b1, "R4");
        step(1'b0, '0, '0, AW'(41), 1'b1, "R4");
    endtask

    task automatic t_nowrite_match;
        step(1'b0, AW'(12), DW'(16'hDEAD), AW'(12), 1'b1, "R5");
        step(1'b0, AW'(13), DW'(16'hBEEF), AW'(13), 1'b1, "R5");
        step(1'b0, '0, '0, AW'(12), 1'b1, "R5");
    endtask

    task automatic t_back_to_back;
        step(1'b1, AW'(50), DW'(16'h0001), AW'(50), 1'b1, "R9");
        step(1'b1, AW'(50), DW'(16'h0002), AW'(50), 1'b1, "R9");
        step(1'b1, AW'(50), DW'(16'h0003), AW'(50), 1'b1, "R9");
        step(1'b0, '0, '0, AW'(50), 1'b1, "R9");
        step(1'b0, '0, '0, AW'(50), 1'b1, "R9");
    endtask

    task automatic t_hold;
        logic [DW-1:0] held;
        step(1'b1, AW'(30), DW'(16'h7777), AW'(30), 1'b1, "R7");
        step(1'b0, '0, '0, AW'(5), 1'b1, "R7");    // staged loads forwarded word
        held = q_stg;
        check("R7", "forwarded word staged", held, 16'h7777);
        step(1'b1, AW'(31), DW'(16'h8888), AW'(31), 1'b0, "R7");
        step(1'b0, '0, '0, AW'(6), 1'b0, "R7");
        check("R7", "staged held", q_stg, held);
    endtask

    task automatic t_direct_ignores_en;
        step(1'b1, AW'(60), DW'(16'h4242), AW'(60), 1'b0, "R8");
        check("R8", "direct forward with enable low", q_dir, 16'h4242);
        step(1'b0, '0, '0, AW'(7), 1'b0, "R8");
        check("R8", "direct read with enable low", q_dir, model[7]);
        step(1'b0, '0, '0, AW'(7), 1'b1, "R8");
    endtask

    task automatic t_random;
        for (int i = 0; i < 400; i++) begin
            logic [AW-1:0] a = AW'($urandom);
            logic [AW-1:0] b = ($urandom % 4 == 0) ? a : AW'($urandom);
            step(1'($urandom), a, DW'($urandom), b, 1'($urandom), "R3");
        end
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) known[i] = 1'b0;
        t_reset();
        t_fill_and_read();
        t_other_addr();
        t_collide();
        t_nowrite_match();
        t_back_to_back();
        t_hold();
        t_direct_ignores_en();
        t_random();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule